// File: doc/BRIEF.md
# Serial Audio Receiver with Source Auto-Switch

This block takes a two-channel serial audio stream on three pins (a word clock that names the channel, a bit clock and a data line) and turns it into parallel 16-bit left/right sample pairs. Each completed pair is presented for one system clock cycle together with a flag that says where the pair came from.

The block shares one output path with an alternate internal pair source, such as a synthesizer stream. It watches the word clock on its own. When the port is enabled and a word clock is present, the output is steered to the serial port. When the word clock stops, the output goes back to the alternate source. A change of source takes effect only at a sample-pair boundary. An activity bit reports whether a word clock is currently present. The enable bit can be written at run time, and its reset value comes from a configuration pin.

Top module: `sarx_top`

## Requirements
- R1: After reset, out_valid and act_o are low, the selected source is the alternate source, and the enable bit equals cfg_en_default.
- R2: A cycle with en_we high loads en_wdata into the enable bit. While the enable bit is low, act_o stays low and no pair with out_src=1 is produced, whatever arrives on the serial pins.
- R3: Serial data is sampled on rising bit-clock edges. Each word is 16 bits, most significant bit first, and its first bit comes one bit-clock period after the word clock changes level. Word clock low carries the left channel and word clock high carries the right channel.
- R4: When a right word completes after a captured left word, the pair (left on out_l, right on out_r) is output with out_valid high for exactly one cycle and out_src=1.
- R5: A word with fewer than 16 bit-clock rising edges since the previous word-clock change is discarded. A right word is output only together with a full left word captured just before it.
- R6: act_o goes high once two word-clock edges arrive no more than timeout_cyc system cycles apart, provided the port is enabled.
- R7: act_o goes low once timeout_cyc system cycles pass with no word-clock edge, or when the port is disabled.
- R8: The serial port is the selected source only while it is enabled and act_o is high. Pairs from it carry out_src=1.
- R9: The source changes only in a cycle that outputs a pair: alternate to port at the next port pair, and port to alternate at the next alt_valid. Alternate pairs are dropped while the port is selected.
- R10: While the alternate source is selected, each alt_valid pair appears on the outputs one cycle later with out_src=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at least four times the bit clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en_default | input | 1 | Value the enable bit takes at reset |
| en_we | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | New enable value |
| timeout_cyc | input | CNT_W (16) | Word-clock timeout in system clock cycles |
| ws_i | input | 1 | Serial word clock (0 = left, 1 = right) |
| bclk_i | input | 1 | Serial bit clock |
| sd_i | input | 1 | Serial data |
| alt_valid | input | 1 | Alternate source pair strobe |
| alt_l | input | SAMPLE_W (16) | Alternate source left sample |
| alt_r | input | SAMPLE_W (16) | Alternate source right sample |
| out_valid | output | 1 | One-cycle strobe of an output pair |
| out_src | output | 1 | Origin of the output pair (1 = serial port, 0 = alternate) |
| out_l | output | SAMPLE_W (16) | Output left sample |
| out_r | output | SAMPLE_W (16) | Output right sample |
| act_o | output | 1 | Word-clock activity status |

## Verification
Twenty frames probe the capture path. The first sixteen walk a single one through the left word and a single zero through the right word. Any shift, reversal or channel swap then shows up as a distinct wrong value. Extreme frames (all ones and all zeros, alternating bits, only the most or least significant bit set) check the first and last bit slots. A short stray word before a valid stream tells apart a receiver that counts bits from one that only watches word-clock edges. Streams sent while disabled, the stop of the clock, and a reset with the enable defaulting high separate the enable, timeout and source-switching behaviour from the capture path.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
    typedef enum logic {
        SRC_ALT  = 1'b0,
        SRC_PORT = 1'b1
    } src_e;

    localparam int unsigned SAMPLE_W_DEF = 16;
    localparam int unsigned CNT_W_DEF    = 16;
endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] stab;
    } sync_t;

    sync_t s_d, s_q;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            always_comb begin
                s_d.meta[g] = async_i[g];
                s_d.stab[g] = s_q.meta[g];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stab;
endmodule

// File: rtl/sarx_deser.sv
module sarx_deser #(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                bclk_s,
    input  logic                ws_s,
    input  logic                sd_s,
    output logic                pair_valid,
    output logic [SAMPLE_W-1:0] pair_l,
    output logic [SAMPLE_W-1:0] pair_r
);
    localparam int unsigned BW = $clog2(SAMPLE_W + 1);
    localparam logic [BW-1:0] BITS_MAX  = BW'(SAMPLE_W);
    localparam logic [BW-1:0] BITS_FULL = BW'(SAMPLE_W - 1);

    typedef struct packed {
        logic                bclk_prev;
        logic                ws_prev;
        logic [SAMPLE_W-1:0] sh;
        logic [SAMPLE_W-1:0] lhold;
        logic                have_l;
        logic [BW-1:0]       bits;
        logic                pv;
        logic [SAMPLE_W-1:0] pl;
        logic [SAMPLE_W-1:0] pr;
    } deser_t;

    deser_t d, q;
    logic   rise;
    logic   full;

    always_comb begin
        d           = q;
        d.pv        = 1'b0;
        d.bclk_prev = bclk_s;
        rise        = bclk_s && !q.bclk_prev;
        full        = (q.bits >= BITS_FULL);
        if (clr) begin
            d.ws_prev = ws_s;
            d.have_l  = 1'b0;
            d.bits    = '0;
        end else if (rise) begin
            d.sh = {q.sh[SAMPLE_W-2:0], sd_s};
            if (ws_s != q.ws_prev) begin
                d.ws_prev = ws_s;
                d.bits    = '0;
                if (!q.ws_prev) begin
                    d.lhold  = d.sh;
                    d.have_l = full;
                end else begin
                    if (full && q.have_l) begin
                        d.pv = 1'b1;
                        d.pl = q.lhold;
                        d.pr = d.sh;
                    end
                    d.have_l = 1'b0;
                end
            end else if (q.bits != BITS_MAX) begin
                d.bits = q.bits + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pair_valid = q.pv;
    assign pair_l     = q.pl;
    assign pair_r     = q.pr;
endmodule

// File: rtl/sarx_detect.sv
module sarx_detect #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ws_s,
    input  logic [CNT_W-1:0] timeout_cyc,
    output logic             present,
    output logic [CNT_W-1:0] idle_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             ws_prev;
        logic [1:0]       streak;
        logic [CNT_W-1:0] cnt;
    } det_t;

    det_t d, q;

    always_comb begin
        d         = q;
        d.ws_prev = ws_s;
        if (clr) begin
            d.streak = 2'd0;
            d.cnt    = '0;
        end else if (ws_s != q.ws_prev) begin
            if (q.streak != 2'd0 && q.cnt < timeout_cyc) d.streak = 2'd2;
            else                                         d.streak = 2'd1;
            d.cnt = '0;
        end else begin
            if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
            if (d.cnt >= timeout_cyc) d.streak = 2'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign present  = (q.streak == 2'd2);
    assign idle_cnt = q.cnt;
endmodule

// File: rtl/sarx_top.sv
module sarx_top
    import sarx_pkg::*;
#(
    parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
    parameter int unsigned CNT_W    = CNT_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_en_default,
    input  logic                en_we,
    input  logic                en_wdata,
    input  logic [CNT_W-1:0]    timeout_cyc,
    input  logic                ws_i,
    input  logic                bclk_i,
    input  logic                sd_i,
    input  logic                alt_valid,
    input  logic [SAMPLE_W-1:0] alt_l,
    input  logic [SAMPLE_W-1:0] alt_r,
    output logic                out_valid,
    output logic                out_src,
    output logic [SAMPLE_W-1:0] out_l,
    output logic [SAMPLE_W-1:0] out_r,
    output logic                act_o
);
    localparam int unsigned PIN_N = 3;

    typedef struct packed {
        logic                en;
        src_e                sel;
        logic                ov;
        src_e                osrc;
        logic [SAMPLE_W-1:0] ol;
        logic [SAMPLE_W-1:0] orr;
    } top_t;

    top_t d, q;

    logic [PIN_N-1:0]    pins_s;
    logic                ws_s, bclk_s, sd_s;
    logic                pair_valid;
    logic [SAMPLE_W-1:0] pair_l, pair_r;
    logic                present;
    logic [CNT_W-1:0]    idle_cnt;
    logic                port_off;
    logic                want_port;
    logic                en_q;
    src_e                sel_q;

    sarx_sync #(.N(PIN_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ws_i, bclk_i, sd_i}),
        .sync_o  (pins_s)
    );

    assign ws_s     = pins_s[2];
    assign bclk_s   = pins_s[1];
    assign sd_s     = pins_s[0];
    assign port_off = !q.en;

    sarx_deser #(.SAMPLE_W(SAMPLE_W)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (port_off),
        .bclk_s     (bclk_s),
        .ws_s       (ws_s),
        .sd_s       (sd_s),
        .pair_valid (pair_valid),
        .pair_l     (pair_l),
        .pair_r     (pair_r)
    );

    sarx_detect #(.CNT_W(CNT_W)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (port_off),
        .ws_s        (ws_s),
        .timeout_cyc (timeout_cyc),
        .present     (present),
        .idle_cnt    (idle_cnt)
    );

    always_comb begin
        d         = q;
        d.ov      = 1'b0;
        want_port = q.en && present;
        if (en_we) d.en = en_wdata;
        if (want_port && pair_valid) begin
            d.sel  = SRC_PORT;
            d.ov   = 1'b1;
            d.osrc = SRC_PORT;
            d.ol   = pair_l;
            d.orr  = pair_r;
        end else if (alt_valid && (q.sel == SRC_ALT || !want_port)) begin
            d.sel  = SRC_ALT;
            d.ov   = 1'b1;
            d.osrc = SRC_ALT;
            d.ol   = alt_l;
            d.orr  = alt_r;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.en   <= cfg_en_default;
            q.sel  <= SRC_ALT;
            q.osrc <= SRC_ALT;
        end else begin
            q <= d;
        end
    end

    assign en_q      = q.en;
    assign sel_q     = q.sel;
    assign out_valid = q.ov;
    assign out_src   = q.osrc;
    assign out_l     = q.ol;
    assign out_r     = q.orr;
    assign act_o     = present;
endmodule

// File: rtl/sarx_checker.sv
module sarx_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_q,
    input logic             sel_q,
    input logic             act_o,
    input logic             out_valid,
    input logic             out_src,
    input logic             alt_valid,
    input logic             pair_valid,
    input logic [CNT_W-1:0] idle_cnt,
    input logic [CNT_W-1:0] timeout_cyc
);
    AST_ACT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        act_o |-> $past(en_q)) else $error("act without enable"); // R2

    AST_PAIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid) else $error("pair strobe too long"); // R4

    AST_ACT_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act_o) |-> ($past(!en_q) || idle_cnt >= timeout_cyc)) else $error("act fell early"); // R7

    AST_PORT_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_src) |-> $past(act_o && en_q)) else $error("port output without activity"); // R8

    AST_SWITCH_ON_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != $past(sel_q)) |-> out_valid) else $error("source switch off boundary"); // R9

    AST_ALT_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_src) |-> $past(alt_valid)) else $error("alt output without strobe"); // R10
endmodule

bind sarx_top sarx_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_q        (en_q),
    .sel_q       (sel_q),
    .act_o       (act_o),
    .out_valid   (out_valid),
    .out_src     (out_src),
    .alt_valid   (alt_valid),
    .pair_valid  (pair_valid),
    .idle_cnt    (idle_cnt),
    .timeout_cyc (timeout_cyc)
);

// File: tb/tb_sarx_top.sv
module tb_sarx_top;
    localparam int W = 16;
    localparam int T = 150;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en_default = 1'b0;
    logic          en_we = 1'b0;
    logic          en_wdata = 1'b0;
    logic [15:0]   timeout_cyc = 16'(T);
    logic          ws_i = 1'b0;
    logic          bclk_i = 1'b1;
    logic          sd_i = 1'b0;
    logic          alt_valid = 1'b0;
    logic [W-1:0]  alt_l = '0;
    logic [W-1:0]  alt_r = '0;
    logic          out_valid, out_src, act_o;
    logic [W-1:0]  out_l, out_r;

    int checks = 0;
    int fails = 0;
    logic pend = 1'b0;
    logic seen_port = 1'b0;
    int alt_mix = 0;
    int alt_cnt = 0;
    int alt_bad = 0;
    logic [W-1:0] exp_l[$], exp_r[$], got_l[$], got_r[$];

    always #5 clk = ~clk;

    sarx_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_en_default(cfg_en_default),
        .en_we(en_we), .en_wdata(en_wdata), .timeout_cyc(timeout_cyc),
        .ws_i(ws_i), .bclk_i(bclk_i), .sd_i(sd_i),
        .alt_valid(alt_valid), .alt_l(alt_l), .alt_r(alt_r),
        .out_valid(out_valid), .out_src(out_src), .out_l(out_l),
        .out_r(out_r), .act_o(act_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor, sampled between edges
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (out_src) begin
                got_l.push_back(out_l);
                got_r.push_back(out_r);
                seen_port = 1'b1;
            end else begin
                alt_cnt++;
                if (out_r !== ~out_l) alt_bad++;
                if (seen_port) alt_mix++;
            end
        end
    end

    // alternate source: a pair every 37 cycles, right = ~left
    initial begin : alt_gen
        logic [W-1:0] seq;
        seq = 16'h0100;
        forever begin
            tick(36);
            alt_valid = 1'b1;
            alt_l = seq;
            alt_r = ~seq;
            seq = seq + 16'h0101;
            tick(1);
            alt_valid = 1'b0;
        end
    end

    task automatic send_slot(input logic ws, input logic bit_v);
        bclk_i = 1'b0;
        ws_i = ws;
        sd_i = bit_v;
        tick(3);
        bclk_i = 1'b1;
        tick(3);
    endtask

    task automatic send_frame(input logic [W-1:0] l, input logic [W-1:0] r, input bit record);
        send_slot(1'b0, pend);
        for (int i = W - 1; i >= 1; i--) send_slot(1'b0, l[i]);
        send_slot(1'b1, l[0]);
        for (int i = W - 1; i >= 1; i--) send_slot(1'b1, r[i]);
        pend = r[0];
        if (record) begin
            exp_l.push_back(l);
            exp_r.push_back(r);
        end
    endtask

    task automatic flush();
        send_slot(1'b0, pend);
    endtask

    task automatic compare(input string req);
        check(req, 32'(got_l.size()), 32'(exp_l.size()));
        for (int i = 0; i < exp_l.size() && i < got_l.size(); i++) begin
            check(req, {got_l[i], got_r[i]}, {exp_l[i], exp_r[i]});
        end
        exp_l.delete(); exp_r.delete(); got_l.delete(); got_r.delete();
    endtask

    task automatic do_reset(input logic def_en);
        rst_n = 1'b0;
        cfg_en_default = def_en;
        ws_i = 1'b0;
        bclk_i = 1'b1;
        pend = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic write_en(input logic v);
        en_we = 1'b1;
        en_wdata = v;
        tick(1);
        en_we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int a0;
        do_reset(1'b0);
        // R1: reset state
        check("R1 out_valid", 32'(out_valid), 0);
        check("R1 act_o", 32'(act_o), 0);

        // R2: disabled port ignores a full stream, alternate keeps flowing
        a0 = alt_cnt;
        for (int i = 0; i < 3; i++) send_frame(16'h1234, 16'h5678, 1'b0);
        flush();
        check("R2 act_o while disabled", 32'(act_o), 0);
        check("R2 no port pairs while disabled", 32'(got_l.size()), 0);
        check("R10 alternate passes", 32'(alt_cnt > a0), 1);

        // R3/R4: walking bits and extremes once enabled
        write_en(1'b1);
        seen_port = 1'b0;
        alt_mix = 0;
        for (int i = 0; i < W; i++)
            send_frame(16'(1) << i, ~(16'(1) << (W - 1 - i)), 1'b1);
        send_frame(16'hFFFF, 16'h0000, 1'b1);
        send_frame(16'hAAAA, 16'h5555, 1'b1);
        send_frame(16'h8000, 16'h0001, 1'b1);
        send_frame(16'h0001, 16'h8000, 1'b1);
        flush();
        tick(2);
        // R6: clock present
        check("R6 act_o while streaming", 32'(act_o), 1);
        compare("R3 R4 pair data");
        // R9: alternate dropped while port selected
        tick(T / 2);
        check("R9 alt pairs dropped while port selected", 32'(alt_mix), 0);
        check("R7 act_o held before timeout", 32'(act_o), 1);
        tick(T);
        // R7: timeout
        check("R7 act_o after timeout", 32'(act_o), 0);
        a0 = alt_cnt;
        tick(100);
        check("R9 back to alternate", 32'(alt_cnt > a0), 1);
        check("R10 alternate pair values", 32'(alt_bad), 0);

        // R5: short stray words are discarded
        for (int i = 0; i < 5; i++) send_slot(1'b1, 1'b1);
        pend = 1'b0;
        send_frame(16'hC3A5, 16'h5A3C, 1'b1);
        send_frame(16'h0F0F, 16'hF0F0, 1'b1);
        flush();
        tick(4);
        compare("R5 short words dropped");

        // R2/R7: disabling clears activity at once
        send_frame(16'h1111, 16'h2222, 1'b0);
        write_en(1'b0);
        tick(3);
        check("R7 act_o after disable", 32'(act_o), 0);
        flush();
        tick(4);
        check("R2 no port pair after disable", 32'(got_l.size()), 0);
        tick(T + 10);

        // R1/R8: reset with enable defaulting high
        do_reset(1'b1);
        check("R1 act_o after reset", 32'(act_o), 0);
        send_frame(16'hBEEF, 16'hCAFE, 1'b1);
        send_frame(16'h7FFF, 16'h8001, 1'b1);
        flush();
        tick(4);
        compare("R8 port selected with default enable");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule